// File: doc/BRIEF.md
# Received Frame Status Queue

This block keeps a short queue of per-frame metadata for a receive path. Each time the receive framer finishes a frame, it presents one push carrying that frame's byte count and three error flags. The block stores these as one entry per frame. The host reads them back in arrival order, so it can find frame boundaries in the separate data stream and pick out the bad frames.

The host sees the entry at the head of the queue through several outputs:

- The length is split across a high field and a low field.
- The error flags appear in a status register, together with a sticky overflow bit.
- A line-status view always mirrors the head entry's error flags.

A status-register read strobe removes the head entry. An interrupt stays high while any stored entry carries an error. The host drains the queue, which needs at most as many reads as there are entries.

The push side is a valid/ready interface, but the framer cannot stall. The block drives `fr_ready` low whenever the queue is full. A push offered while `fr_ready` is low is dropped, not held, and it records an overflow. `fr_ready` depends only on the fill level. It does not depend on `fr_valid` or on a same-cycle pop.

Top module: `frame_stat_fifo`

## Requirements
- R1: After reset the queue is empty.
  - `nonempty`, `irq`, `len_hi`, `len_lo`, `stat_reg` and `line_err` are all zero.
  - `fr_ready` is 1.
- R2: A push with `fr_valid`=1 and `fr_ready`=1 is stored at the rising edge. Entries leave in the order they arrived.
- R3: The queue holds 8 entries. With 8 stored, `fr_ready` is 0. A push in that state is dropped and leaves every stored entry unchanged, even if a pop happens in the same cycle.
- R4: A dropped push sets `stat_reg[3]`, the sticky overflow bit. The bit stays set until a cycle with `stat_rd`=1, which clears it. If a drop happens in the same cycle as that read, the bit stays set.
- R5: The head entry's 12-bit length is split across two outputs: `len_hi` = length[11:8] and `len_lo` = length[7:0].
- R6: `stat_reg[2:0]` shows the head entry's errors with bit 2 = frame-length error, bit 1 = CRC error and bit 0 = abort. This order is the same as in `fr_err`.
- R7: `line_err` always equals the head entry's error field, and is zero when the queue is empty.
- R8: A cycle with `stat_rd`=1 and a non-empty queue removes exactly the head entry. Holding length values on the outputs does not remove anything.
- R9: While the queue is empty, all head outputs read as zero, and `stat_rd` does not move the read position. A push in the same cycle as such a read is stored and becomes the head.
- R10: `irq` is 1 exactly when at least one stored entry has a nonzero error field.
- R11: `nonempty` is 1 exactly when at least one entry is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | End-of-frame push from the framer |
| fr_ready | output | 1 | Queue can accept a push (not full) |
| fr_len | input | 12 | Byte count of the finished frame |
| fr_err | input | 3 | {frame-length error, CRC error, abort} |
| stat_rd | input | 1 | Status register read strobe; pops the head entry |
| len_hi | output | 4 | Head entry length bits 11:8 |
| len_lo | output | 8 | Head entry length bits 7:0 |
| stat_reg | output | 4 | {sticky overflow, head error field} |
| line_err | output | 3 | Line-status mirror of the head error field |
| nonempty | output | 1 | At least one entry stored |
| irq | output | 1 | Some stored entry has an error |

## Verification
The assertions assume that `stat_rd` and `fr_valid` are clean one-cycle-sampled levels and that `rst_n` is applied for at least one clock before use. They also assume that the framer never relies on a push being held while `fr_ready` is low. The bench changes every input only on the falling edge and samples on the following falling edge. It deliberately offers pushes into a full queue and reads from an empty one, because both are defined behaviour and not protocol violations.

// File: rtl/frame_stat_pkg.sv
package frame_stat_pkg;
  localparam int LEN_W = 12;
  localparam int HI_W  = 4;
  localparam int LO_W  = LEN_W - HI_W;
  localparam int ERR_W = 3;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [ERR_W-1:0] err;  // {length error, crc error, abort}
  } fstat_t;
endpackage

// File: rtl/fsf_store.sv
module fsf_store
  import frame_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  fstat_t        push_ent,
  input  logic          pop,
  output fstat_t        head,
  output logic          full,
  output logic          empty,
  output logic          push_acc,
  output logic          pop_acc
);
  fstat_t          mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_acc = push && !full;
  assign pop_acc  = pop && !empty;
  assign head     = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= nxt(wr_ptr);
      if (pop_acc)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_acc) - CW'(pop_acc);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (push_acc && wr_ptr == PW'(g)) mem[g] <= push_ent;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
  assert_pop_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
  assert_empty_pop_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rd_ptr));
endmodule

// File: rtl/fsf_err_track.sv
module fsf_err_track
  import frame_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_acc,
  input  logic [ERR_W-1:0] push_err,
  input  logic             pop_acc,
  input  logic [ERR_W-1:0] head_err,
  input  logic             empty,
  output logic             irq
);
  logic [CW-1:0] bad_cnt;
  logic inc, dec;

  assign inc = push_acc && (push_err != '0);
  assign dec = pop_acc && (head_err != '0);
  assign irq = (bad_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) bad_cnt <= '0;
    else        bad_cnt <= bad_cnt + CW'(inc) - CW'(dec);
  end

  assert_irq_needs_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !empty);
endmodule

// File: rtl/fsf_host_view.sv
module fsf_host_view
  import frame_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  fstat_t          head,
  input  logic            empty,
  input  logic            drop,
  input  logic            stat_rd,
  output logic [HI_W-1:0] len_hi,
  output logic [LO_W-1:0] len_lo,
  output logic [3:0]      stat_reg,
  output logic [ERR_W-1:0] line_err
);
  logic ovf_q;
  fstat_t vis;

  assign vis      = empty ? '0 : head;
  assign len_hi   = vis.len[LEN_W-1:LO_W];
  assign len_lo   = vis.len[LO_W-1:0];
  assign stat_reg = {ovf_q, vis.err};
  assign line_err = vis.err;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (drop)    ovf_q <= 1'b1;
    else if (stat_rd) ovf_q <= 1'b0;
  end

  assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(drop));
  assert_ovf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !drop) |=> !ovf_q);
endmodule

// File: rtl/frame_stat_fifo.sv
module frame_stat_fifo
  import frame_stat_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fr_valid,
  output logic        fr_ready,
  input  logic [11:0] fr_len,
  input  logic [2:0]  fr_err,
  input  logic        stat_rd,
  output logic [3:0]  len_hi,
  output logic [7:0]  len_lo,
  output logic [3:0]  stat_reg,
  output logic [2:0]  line_err,
  output logic        nonempty,
  output logic        irq
);
  fstat_t head, in_ent;
  logic full, empty, push_acc, pop_acc;

  assign in_ent   = '{len: fr_len, err: fr_err};
  assign fr_ready = !full;
  assign nonempty = !empty;

  fsf_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .push(fr_valid), .push_ent(in_ent),
    .pop(stat_rd), .head(head), .full(full), .empty(empty),
    .push_acc(push_acc), .pop_acc(pop_acc)
  );

  fsf_err_track #(.DEPTH(DEPTH)) err_i (
    .clk(clk), .rst_n(rst_n), .push_acc(push_acc), .push_err(fr_err),
    .pop_acc(pop_acc), .head_err(head.err), .empty(empty), .irq(irq)
  );

  fsf_host_view view_i (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty),
    .drop(fr_valid && full), .stat_rd(stat_rd),
    .len_hi(len_hi), .len_lo(len_lo), .stat_reg(stat_reg), .line_err(line_err)
  );

  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_err == stat_reg[2:0]);
  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |-> (len_hi == '0 && len_lo == '0 && line_err == '0));
  assert_first_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonempty && fr_valid) |=> nonempty);
endmodule

// File: tb/frame_stat_fifo_tb.sv
module frame_stat_fifo_tb_top;
  logic clk = 0, rst_n = 0;
  logic fr_valid = 0, stat_rd = 0;
  logic [11:0] fr_len = 0;
  logic [2:0] fr_err = 0;
  logic fr_ready, nonempty, irq;
  logic [3:0] len_hi, stat_reg;
  logic [7:0] len_lo;
  logic [2:0] line_err;
  int n_chk = 0, n_bad = 0;
  int q_id[$];
  bit wd_fired = 0;

  always #2.5 clk = ~clk;

  frame_stat_fifo dut_i (.*);

  function automatic logic [11:0] elen(int id); return 12'((id * 397 + 5) & 12'hFFF); endfunction
  function automatic logic [2:0]  eerr(int id); return 3'((id * 3) & 7); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit any_err();
    foreach (q_id[i]) if (eerr(q_id[i]) != 0) return 1;
    return 0;
  endfunction

  // checks head outputs against the model queue
  task automatic chk_head(string req);
    if (q_id.size() == 0) begin
      chk({req, " R9 empty len"}, {len_hi, len_lo}, 0);
      chk({req, " R9 empty err"}, stat_reg[2:0], 0);
      chk({req, " R7 empty line"}, line_err, 0);
    end else begin
      chk({req, " R5 len_hi"}, len_hi, elen(q_id[0]) >> 8);
      chk({req, " R5 len_lo"}, len_lo, elen(q_id[0]) & 8'hFF);
      chk({req, " R6 err"}, stat_reg[2:0], eerr(q_id[0]));
      chk({req, " R7 line"}, line_err, eerr(q_id[0]));
    end
    chk({req, " R11 nonempty"}, nonempty, q_id.size() != 0);
    chk({req, " R10 irq"}, irq, any_err());
    chk({req, " R3 ready"}, fr_ready, q_id.size() < 8);
  endtask

  // one cycle: optional push and/or read, driven at negedge, effect seen next negedge
  task automatic cyc(bit p, int id, bit r);
    bit room;
    room = q_id.size() < 8;
    fr_valid = p; fr_len = elen(id); fr_err = eerr(id); stat_rd = r;
    @(negedge clk);
    fr_valid = 0; stat_rd = 0;
    if (r && q_id.size() != 0) void'(q_id.pop_front());
    if (p && room) q_id.push_back(id);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_head("R1 reset");
    chk("R1 ovf", stat_reg[3], 0);
    // R2/R8 sweep over every fill level
    for (int n = 0; n <= 8; n++) begin
      for (int k = 0; k < n; k++) cyc(1, n * 16 + k, 0);
      chk_head("R2 filled");
      chk("R4 no ovf", stat_reg[3], 0);
      for (int k = 0; k < n; k++) begin cyc(0, 0, 1); chk_head("R8 drain"); end
      cyc(0, 0, 1);
      chk_head("R9 read empty");
    end
    // R3/R4 overflow
    for (int k = 0; k < 8; k++) cyc(1, 200 + k, 0);
    chk("R3 full ready", fr_ready, 0);
    cyc(1, 300, 0);
    chk_head("R3 after drop");
    chk("R4 ovf set", stat_reg[3], 1);
    cyc(0, 0, 0);
    chk("R4 ovf sticky", stat_reg[3], 1);
    cyc(1, 301, 1);  // pop and drop together: drop wins, entry not stored
    chk_head("R3 drop with pop");
    chk("R4 ovf set over read", stat_reg[3], 1);
    cyc(0, 0, 1);
    chk("R4 ovf cleared", stat_reg[3], 0);
    chk_head("R8 after clear");
    while (q_id.size() != 0) begin cyc(0, 0, 1); chk_head("R3 drain no dropped"); end
    // R9 push with read while empty
    cyc(1, 400, 1);
    chk_head("R9 push on empty read");
    cyc(1, 401, 1);  // push and pop with one entry
    chk_head("R2 push pop");
    cyc(0, 0, 1);
    chk_head("R11 final empty");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    wd_fired = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule